// File: doc/BRIEF.md
# Multi-Bank GPIO Port Register File

This block holds the per-pin setup and data state for eight general-purpose I/O banks. A simple register port reaches it. Each bank has three registers: a configuration word, a data word and a pull-up word. The configuration word chooses a mode for each pin. A pin in input mode copies its external level into the data word on every clock. A pin in output mode drives the data word onto the pad, together with an output enable. A pin in interrupt mode, or in the reserved mode, holds whatever was last written to it.

Bank 0 uses one configuration bit per pin, and a 0 marks an output. Banks 1 to 7 use a two-bit field per pin. After each data write, the block raises a one-cycle strobe for every output pin whose level changed, so that downstream pad or model logic reacts only to real edges. The pull-up words are plain storage.

The bank pin counts are, in order, 23, 11, 16, 16, 16, 8, 16 and 11. Pin i of bank b sits at bit 32*b+i of every pin-wide port.

Top module: `gpio_port_regs`

## Requirements
- R1: Bank b occupies byte addresses 16*b to 16*b+15. Its configuration register is at offset 0x0, its data register at offset 0x4 and its pull-up register at offset 0x8. A write with wr_en_i high stores wdata_i on the clock edge, and rdata_o returns the stored value combinationally from addr_i.
- R2: Unmapped addresses read as 0, and writes to them change no register and raise no strobe. The unmapped addresses are offset 0xC inside any bank and every address from 0x80 up.
- R3: Reset values are as follows. Configuration is 0x07ffffff in bank 0 and 0 in the other banks. Every data register is 0. Every pull-up register is 0, except bank 3 at 0x0000f000 and bank 6 at 0x0000f800.
- R4: In bank 0, configuration bit i = 0 makes pin i an output: pin_oe_o is high and pin_o carries data bit i. Configuration bit i = 1 disables the output. Bank 0 never captures pin levels.
- R5: In banks 1 to 7, pin i uses configuration bits [2i+1:2i]. Code 0 is input, code 1 is output (pin_oe_o high) and codes 2 and 3 are neither.
- R6: The data bit of an input-mode pin equals pin_i as sampled at the previous clock edge. A data write does not override it.
- R7: In the cycle after a data write, chg_o has a 1 for each output pin whose data bit differs from its value before the write. chg_o is zero in every cycle that does not follow a data write.
- R8: Pins at or above a bank's pin count are never output-enabled, never captured and never strobed. Their data bits still store written values.
- R9: Pull-up registers are storage only. Writing them affects no pin output, output enable, strobe or data bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 8 | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i |
| pin_i | input | 256 | External pin levels, bank b pin i at bit 32*b+i |
| pin_o | output | 256 | Driven pin levels (data registers) |
| pin_oe_o | output | 256 | Output enable per pin |
| chg_o | output | 256 | One-cycle changed-output strobe per pin |

## Verification
Four properties are checked on every cycle:
- a strobe always follows a data write;
- a strobed pin's data bit really changed;
- input-mode data bits track the previous pin sample;
- pull-up and configuration state stays still when nothing writes it, including under unmapped writes.

The bench scenarios cover the rest:
- the exact decoding of each mode code and of bank 0's inverted single-bit encoding;
- the reset constants;
- the pin-count boundaries;
- readback through the address map, including the alias address 0x84.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int unsigned NUM_BANKS  = 8;
  localparam int unsigned REG_W      = 32;
  localparam int unsigned BANK_SPAN  = 16;
  localparam int unsigned OFS_W      = $clog2(BANK_SPAN);
  localparam int unsigned BANK_IDX_W = $clog2(NUM_BANKS);
  localparam int unsigned ADDR_W     = OFS_W + BANK_IDX_W + 1;
  localparam int unsigned PORT_W     = NUM_BANKS * REG_W;

  localparam logic [OFS_W-1:0] OFS_CFG = 4'h0;
  localparam logic [OFS_W-1:0] OFS_DAT = 4'h4;
  localparam logic [OFS_W-1:0] OFS_PU  = 4'h8;

  typedef enum logic [1:0] {REG_CFG, REG_DAT, REG_PU, REG_NONE} reg_kind_e;
  typedef enum logic [1:0] {MODE_IN = 2'd0, MODE_OUT = 2'd1, MODE_IRQ = 2'd2, MODE_RSV = 2'd3} pin_mode_e;

  function automatic int unsigned pin_count(input int unsigned b);
    case (b)
      0: return 23;
      1: return 11;
      2, 3, 4, 6: return 16;
      5: return 8;
      default: return 11;
    endcase
  endfunction

  function automatic logic [REG_W-1:0] cfg_reset(input int unsigned b);
    return (b == 0) ? 32'h07ff_ffff : '0;
  endfunction

  function automatic logic [REG_W-1:0] pu_reset(input int unsigned b);
    case (b)
      3: return 32'h0000_f000;
      6: return 32'h0000_f800;
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/gpio_port_dec.sv
module gpio_port_dec
  import gpio_port_pkg::*;
(
  input  logic [ADDR_W-1:0]    addr_i,
  output logic [NUM_BANKS-1:0] bank_sel_o,
  output reg_kind_e            kind_o
);
  logic in_range;

  always_comb begin
    in_range = addr_i < ADDR_W'(NUM_BANKS * BANK_SPAN);
    unique case (addr_i[OFS_W-1:0])
      OFS_CFG: kind_o = REG_CFG;
      OFS_DAT: kind_o = REG_DAT;
      OFS_PU:  kind_o = REG_PU;
      default: kind_o = REG_NONE;
    endcase
    if (!in_range) kind_o = REG_NONE;
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_sel
    assign bank_sel_o[b] = (kind_o != REG_NONE) &&
                           (addr_i[OFS_W +: BANK_IDX_W] == BANK_IDX_W'(b));
  end
endmodule

// File: rtl/gpio_port_bank.sv
module gpio_port_bank
  import gpio_port_pkg::*;
#(
  parameter int unsigned BANK_IDX = 0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic             sel_i,
  input  reg_kind_e        kind_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic [REG_W-1:0] pin_i,
  output logic [REG_W-1:0] cfg_o,
  output logic [REG_W-1:0] dat_o,
  output logic [REG_W-1:0] pu_o,
  output logic [REG_W-1:0] oe_o,
  output logic [REG_W-1:0] chg_o
);
  localparam int unsigned      PINS    = pin_count(BANK_IDX);
  localparam logic [REG_W-1:0] CFG_RST = cfg_reset(BANK_IDX);
  localparam logic [REG_W-1:0] PU_RST  = pu_reset(BANK_IDX);

  logic [REG_W-1:0] cfg_q, dat_q, pu_q, chg_q;
  logic [REG_W-1:0] is_in, is_out, dat_nxt, chg_nxt;
  logic             wr_cfg, wr_dat, wr_pu;

  // per-pin mode decode; bank 0 is one bit per pin, 0 = output, no input mode
  for (genvar i = 0; i < int'(REG_W); i++) begin : g_pin
    if (i >= int'(PINS)) begin : g_none
      assign is_in[i]  = 1'b0;
      assign is_out[i] = 1'b0;
    end else if (BANK_IDX == 0) begin : g_one
      assign is_in[i]  = 1'b0;
      assign is_out[i] = ~cfg_q[i];
    end else if (2 * i + 1 < int'(REG_W)) begin : g_two
      assign is_in[i]  = cfg_q[2*i+1:2*i] == 2'(MODE_IN);
      assign is_out[i] = cfg_q[2*i+1:2*i] == 2'(MODE_OUT);
    end else begin : g_far
      assign is_in[i]  = 1'b0;
      assign is_out[i] = 1'b0;
    end
  end

  assign wr_cfg = wr_en_i && sel_i && kind_i == REG_CFG;
  assign wr_dat = wr_en_i && sel_i && kind_i == REG_DAT;
  assign wr_pu  = wr_en_i && sel_i && kind_i == REG_PU;

  always_comb begin
    dat_nxt = wr_dat ? wdata_i : dat_q;
    dat_nxt = (dat_nxt & ~is_in) | (pin_i & is_in);
    chg_nxt = wr_dat ? ((dat_q ^ wdata_i) & is_out) : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= CFG_RST;
      dat_q <= '0;
      pu_q  <= PU_RST;
      chg_q <= '0;
    end else begin
      if (wr_cfg) cfg_q <= wdata_i;
      if (wr_pu)  pu_q  <= wdata_i;
      dat_q <= dat_nxt;
      chg_q <= chg_nxt;
    end
  end

  assign cfg_o = cfg_q;
  assign dat_o = dat_q;
  assign pu_o  = pu_q;
  assign oe_o  = is_out;
  assign chg_o = chg_q;

  AST_CHG_AFTER_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|chg_q) |-> $past(wr_dat)); // R7
  AST_CHG_IS_REAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> ((chg_q & ~(dat_q ^ $past(dat_q))) == '0)); // R7
  AST_INPUT_TRACKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> (((dat_q ^ $past(pin_i)) & $past(is_in)) == '0)); // R6
  AST_PU_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && !$past(wr_pu)) |-> $stable(pu_q)); // R9
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_port_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [7:0]        addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  input  logic [255:0]      pin_i,
  output logic [255:0]      pin_o,
  output logic [255:0]      pin_oe_o,
  output logic [255:0]      chg_o
);
  logic [NUM_BANKS-1:0]             bank_sel;
  reg_kind_e                        kind;
  logic [NUM_BANKS-1:0][REG_W-1:0]  cfg_w, dat_w, pu_w;

  gpio_port_dec i_dec (
    .addr_i     (addr_i),
    .bank_sel_o (bank_sel),
    .kind_o     (kind)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    gpio_port_bank #(.BANK_IDX(b)) i_bank (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_en_i (wr_en_i),
      .sel_i   (bank_sel[b]),
      .kind_i  (kind),
      .wdata_i (wdata_i),
      .pin_i   (pin_i[b*REG_W +: REG_W]),
      .cfg_o   (cfg_w[b]),
      .dat_o   (dat_w[b]),
      .pu_o    (pu_w[b]),
      .oe_o    (pin_oe_o[b*REG_W +: REG_W]),
      .chg_o   (chg_o[b*REG_W +: REG_W])
    );
    assign pin_o[b*REG_W +: REG_W] = dat_w[b];
  end

  always_comb begin
    rdata_o = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (bank_sel[b]) begin
        unique case (kind)
          REG_CFG: rdata_o = cfg_w[b];
          REG_DAT: rdata_o = dat_w[b];
          REG_PU:  rdata_o = pu_w[b];
          default: rdata_o = '0;
        endcase
      end
    end
  end

  AST_UNMAPPED_INERT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !(|bank_sel)) |=> ($stable(cfg_w) && $stable(pu_w))); // R2
endmodule

// File: tb/test_gpio_port_regs.sv
`timescale 1ns/1ps
module test_gpio_port_regs;
  logic         clk = 1'b0;
  logic         rst_ni;
  logic         wr_en;
  logic [7:0]   addr;
  logic [31:0]  wdata;
  logic [31:0]  rdata;
  logic [255:0] pin_i, pin_o, pin_oe, chg;
  logic [255:0] last_chg;
  int           n_chk = 0, n_fail = 0;
  bit           done = 0;

  always #4 clk = ~clk;

  gpio_port_regs i_gpio_port_regs (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .pin_i(pin_i), .pin_o(pin_o), .pin_oe_o(pin_oe), .chg_o(chg)
  );

  // {addr, wdata, expected readback}
  localparam logic [71:0] VEC [7] = '{
    {8'h10, 32'h0000_5555, 32'h0000_5555},  // R1 bank1 cfg
    {8'h18, 32'h0000_07ff, 32'h0000_07ff},  // R9 bank1 pull-up
    {8'h70, 32'haaaa_aaaa, 32'haaaa_aaaa},  // R5 bank7 all interrupt mode
    {8'h74, 32'h1234_5678, 32'h1234_5678},  // R1 bank7 data held
    {8'h54, 32'h0000_ff0f, 32'h0000_ff00},  // R8 bank5 inputs captured, upper bits stored
    {8'h3c, 32'h0000_dead, 32'h0000_0000},  // R2 offset 0xC
    {8'h9c, 32'hffff_ffff, 32'h0000_0000}   // R2 beyond map
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    #1;
    last_chg = chg;
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    @(negedge clk);
    addr = a;
    #1;
    v = rdata;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    #800000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog act=hung exp=done");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    rst_ni = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0; pin_i = '0; last_chg = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_ni = 1'b1;

    // R3 reset state
    for (int b = 0; b < 8; b++) begin
      rd(8'(b * 16), v);     chk("R3 cfg", v, (b == 0) ? 32'h07ff_ffff : 32'h0);
      rd(8'(b * 16 + 4), v); chk("R3 data", v, 32'h0);
      rd(8'(b * 16 + 8), v);
      chk("R3 pull-up", v, (b == 3) ? 32'h0000_f000 : (b == 6) ? 32'h0000_f800 : 32'h0);
    end
    chk("R3 no output enables", {31'b0, |pin_oe}, 32'h0);
    chk("R3 no strobes", {31'b0, |chg}, 32'h0);

    // table walk
    for (int i = 0; i < 7; i++) begin
      wr(VEC[i][71:64], VEC[i][63:32]);
      rd(VEC[i][71:64], v);
      chk($sformatf("R1/R2/R5/R8/R9 table %0d", i), v, VEC[i][31:0]);
    end

    // R4 bank 0 single-bit encoding
    wr(8'h00, 32'h07ff_ff00);
    chk("R4 bank0 oe", pin_oe[31:0], 32'h0000_00ff);
    wr(8'h04, 32'h0000_00a5);
    chk("R7 bank0 first change", last_chg[31:0], 32'h0000_00a5);
    chk("R4 bank0 pin_o", pin_o[31:0], 32'h0000_00a5);
    pin_i[31:0] = '1;
    repeat (2) @(negedge clk);
    rd(8'h04, v);
    chk("R4 bank0 no capture", v, 32'h0000_00a5);
    wr(8'h04, 32'h0000_00a5);
    chk("R7 same value no strobe", last_chg[31:0], 32'h0);
    wr(8'h04, 32'h0000_005a);
    chk("R7 toggle strobe", last_chg[31:0], 32'h0000_00ff);
    @(posedge clk); #1;
    chk("R7 strobe one cycle", {31'b0, |chg}, 32'h0);
    pin_i[31:0] = '0;

    // R5/R6 bank 2 mixed modes: pin0 out, pin1 irq, pin2 out, rest input
    wr(8'h20, 32'h0000_0019);
    chk("R5 bank2 oe", pin_oe[95:64], 32'h0000_0005);
    pin_i[95:64] = 32'h0000_ffff;
    repeat (2) @(negedge clk);
    rd(8'h24, v);
    chk("R6 capture high", v, 32'h0000_fff8);
    wr(8'h24, 32'hffff_0007);
    chk("R7 bank2 strobe", last_chg[95:64], 32'h0000_0005);
    rd(8'h24, v);
    chk("R6 R8 write merge", v, 32'hffff_ffff);
    pin_i[95:64] = '0;
    repeat (2) @(negedge clk);
    rd(8'h24, v);
    chk("R6 capture low", v, 32'hffff_0007);
    wr(8'h24, 32'h0000_fff8);
    chk("R7 falling strobe", last_chg[95:64], 32'h0000_0005);
    rd(8'h24, v);
    chk("R6 write cannot override input", v, 32'h0);

    // R8 bank 5 pin-count boundary
    wr(8'h50, 32'h5555_5555);
    chk("R8 bank5 oe limited", pin_oe[191:160], 32'h0000_00ff);
    wr(8'h54, 32'h00ff_00ff);
    chk("R8 bank5 strobe limited", last_chg[191:160], 32'h0000_00ff);
    rd(8'h54, v);
    chk("R8 upper bits stored", v, 32'h00ff_00ff);

    // R9 pull-up has no side effect
    wr(8'h28, 32'h0000_ffff);
    chk("R9 no strobe", {31'b0, |last_chg}, 32'h0);
    chk("R9 oe unchanged", pin_oe[95:64], 32'h0000_0005);
    rd(8'h28, v); chk("R9 readback", v, 32'h0000_ffff);
    rd(8'h24, v); chk("R9 data unchanged", v, 32'h0);

    // R2 alias of bank0 data above the map
    wr(8'h84, 32'hffff_ffff);
    chk("R2 alias no strobe", {31'b0, |last_chg}, 32'h0);
    rd(8'h04, v); chk("R2 alias bank0 data kept", v, 32'h0000_005a);
    rd(8'h84, v); chk("R2 alias reads zero", v, 32'h0);

    done = 1;
    summary();
    $finish;
  end
endmodule